// File: doc/BRIEF.md
# Opmask OR-Test Flag Unit

This unit holds eight 64-bit opmask registers and runs a test on them. The test ORs two chosen masks together and keeps only the low bits of the active operand width. From that result it produces a new set of arithmetic status flags. The zero flag reports that the kept bits are all clear. The carry flag reports that the kept bits are all set. The overflow, sign, auxiliary-carry and parity flags are always written as zero.

Each test is started by a one-cycle issue pulse. The pulse comes with two 3-bit register selectors and two decoded instruction bits: one says whether the operand-size prefix is present, the other is the width bit. Together these two bits pick one of four operand widths. The flags and a valid strobe come out of registers one clock after the pulse. A separate write port loads the mask registers, and a test never changes them.

Top module: `kmask_ortest`

## Requirements
- R1: A synchronous active-low reset clears all eight mask registers, every flag output and the valid strobe to zero. A test issued after reset, at any width and on any pair of registers, reports zero flag 1 and carry flag 0.
- R2: A register write lands on the clock edge. A test issued in the same cycle that reads the register being written sees the old contents. A test in a later cycle sees the new contents.
- R3: The test ORs the two selected registers and keeps bits [N-1:0], where N is the operand width. `flag_zf` is 1 exactly when those N bits are all zero.
- R4: `flag_cf` is 1 exactly when all N kept bits are one. At the 16-bit width this means the kept value equals 0xFFFF.
- R5: The operand width is set by {`pfx66`, `wbit`` as follows: 00 gives 16 bits, 10 gives 8 bits, 11 gives 32 bits, and 01 gives 64 bits.
- R6: Source bits at positions N and above have no effect on either flag.
- R7: `flag_of`, `flag_sf`, `flag_af` and `flag_pf` are always 0.
- R8: `flags_vld` is 1 in exactly the cycle after an issue pulse and 0 otherwise. The new flags appear in that same cycle.
- R9: In a cycle with no issue, `flag_zf` and `flag_cf` keep their values, whatever the selectors and decode bits do.
- R10: A test leaves both source registers unchanged. Repeated tests on the same registers give flags that match the register contents last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write enable for the mask register file |
| wr_idx | input | 3 | Index of the register to write |
| wr_data | input | 64 | Value to write |
| issue | input | 1 | One-cycle pulse that starts a test |
| src_a_idx | input | 3 | First source register index |
| src_b_idx | input | 3 | Second source register index |
| pfx66 | input | 1 | Operand-size prefix present |
| wbit | input | 1 | Width bit of the decoded instruction |
| flags_vld | output | 1 | Flags were updated in this cycle |
| flag_zf | output | 1 | Zero flag: kept OR result is all zeros |
| flag_cf | output | 1 | Carry flag: kept OR result is all ones |
| flag_of | output | 1 | Overflow flag, always 0 |
| flag_sf | output | 1 | Sign flag, always 0 |
| flag_af | output | 1 | Auxiliary-carry flag, always 0 |
| flag_pf | output | 1 | Parity flag, always 0 |

## Verification
The assertions assume that `issue` is a clean, known level on every clock edge. They also assume that reset is held low for at least one edge before the first issue. The bench drives every input on the falling edge and keeps `issue` at 0 through reset and between tests.

The assertion that zero and carry are never both set relies on every operand width being at least one bit. All four decoded widths meet this, and the stimulus sweeps through all four of them.

// File: rtl/kmask_pkg.sv
// Package: shared types for the opmask OR-test unit.
// Holds the operand-width code, the flag bundle, and the mapping from a
// width code to a bit count.
package kmask_pkg;

    // Operand width code. Bit count = 8 << code.
    typedef enum logic [1:0] {
        KW_8  = 2'd0,
        KW_16 = 2'd1,
        KW_32 = 2'd2,
        KW_64 = 2'd3
    } kwidth_e;

    // Status flag bundle written by one test.
    typedef struct packed {
        logic zf;
        logic cf;
        logic of;
        logic sf;
        logic af;
        logic pf;
    } kflags_t;

    // Number of operand bits selected by a width code.
    function automatic int kwidth_bits(kwidth_e w);
        return 8 << int'(w);
    endfunction

endpackage

// File: rtl/kmask_regfile.sv
// Module: kmask_regfile
// Mask register file with one write port and two combinational read ports.
// Assumes: the write lands on the clock edge, so a read in the same cycle
// returns the old value. Synchronous active-low reset clears every entry.
module kmask_regfile #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 64,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic [SEL_W-1:0] rd_a_idx,
    input  logic [SEL_W-1:0] rd_b_idx,
    output logic [REG_W-1:0] rd_a_data,
    output logic [REG_W-1:0] rd_b_data
);

    logic [REG_W-1:0] regs_q [NUM_REGS];

    // One flop bank per entry; each entry loads only when its index is written.
    for (genvar e = 0; e < NUM_REGS; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[e] <= '0;
            end else if (wr_en && (int'(wr_idx) == e)) begin
                regs_q[e] <= wr_data;
            end
        end
    end

    // Combinational read of both source entries.
    always_comb begin
        rd_a_data = regs_q[rd_a_idx];
        rd_b_data = regs_q[rd_b_idx];
    end

endmodule

// File: rtl/kmask_width_dec.sv
// Module: kmask_width_dec
// Turns the operand-size prefix bit and the width bit into a width code.
// Assumes: both inputs are already decoded from the instruction.
module kmask_width_dec
    import kmask_pkg::*;
(
    input  logic    pfx66,
    input  logic    wbit,
    output kwidth_e width_sel
);

    // Map {prefix, W} to one of the four operand widths.
    always_comb begin
        unique case ({pfx66, wbit})
            2'b00:   width_sel = KW_16;
            2'b10:   width_sel = KW_8;
            2'b01:   width_sel = KW_64;
            default: width_sel = KW_32;
        endcase
    end

endmodule

// File: rtl/kmask_flag_eval.sv
// Module: kmask_flag_eval
// ORs two masks, keeps the bits below the operand width, and tests the
// result for all-zero and all-one.
// Assumes: every width code gives at least one bit. Widths larger than
// REG_W are clipped to REG_W.
module kmask_flag_eval
    import kmask_pkg::*;
#(
    parameter int REG_W = 64
) (
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  kwidth_e          width_sel,
    output logic             all_zero,
    output logic             all_ones
);

    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] or_val;

    // Per-bit lane enable: set when bit b lies inside the operand width.
    for (genvar b = 0; b < REG_W; b++) begin : g_lane
        assign lane_mask[b] = (b < kwidth_bits(width_sel));
    end

    // OR the sources, then reduce the kept lanes in two ways.
    always_comb begin
        or_val   = src_a | src_b;
        all_zero = ~|(or_val & lane_mask);
        all_ones = &(or_val | ~lane_mask);
    end

endmodule

// File: rtl/kmask_ortest.sv
// Module: kmask_ortest (top)
// Opmask OR-test unit. It holds the mask register file, decodes the
// operand width, evaluates the flags, and registers the flags and the valid
// strobe one clock after issue.
// Assumes: issue is a single-cycle pulse, and reset is synchronous and
// active low.
module kmask_ortest
    import kmask_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 64,
    localparam int SEL_W   = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    input  logic             issue,
    input  logic [SEL_W-1:0] src_a_idx,
    input  logic [SEL_W-1:0] src_b_idx,
    input  logic             pfx66,
    input  logic             wbit,
    output logic             flags_vld,
    output logic             flag_zf,
    output logic             flag_cf,
    output logic             flag_of,
    output logic             flag_sf,
    output logic             flag_af,
    output logic             flag_pf
);

    logic [REG_W-1:0] rd_a;
    logic [REG_W-1:0] rd_b;
    kwidth_e          width_sel;
    logic             eval_zero;
    logic             eval_ones;
    kflags_t          flags_q;
    logic             vld_q;

    kmask_regfile #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W)
    ) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .rd_a_idx  (src_a_idx),
        .rd_b_idx  (src_b_idx),
        .rd_a_data (rd_a),
        .rd_b_data (rd_b)
    );

    kmask_width_dec u_wdec (
        .pfx66     (pfx66),
        .wbit      (wbit),
        .width_sel (width_sel)
    );

    kmask_flag_eval #(
        .REG_W (REG_W)
    ) u_eval (
        .src_a     (rd_a),
        .src_b     (rd_b),
        .width_sel (width_sel),
        .all_zero  (eval_zero),
        .all_ones  (eval_ones)
    );

    // Capture new flags on issue and keep them otherwise; valid follows issue by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= issue;
            if (issue) begin
                flags_q.zf <= eval_zero;
                flags_q.cf <= eval_ones;
                flags_q.of <= 1'b0;
                flags_q.sf <= 1'b0;
                flags_q.af <= 1'b0;
                flags_q.pf <= 1'b0;
            end
        end
    end

    // Drive the output ports from the flag register.
    always_comb begin
        flags_vld = vld_q;
        flag_zf   = flags_q.zf;
        flag_cf   = flags_q.cf;
        flag_of   = flags_q.of;
        flag_sf   = flags_q.sf;
        flag_af   = flags_q.af;
        flag_pf   = flags_q.pf;
    end

endmodule

// File: rtl/kmask_ortest_chk.sv
// Module: kmask_ortest_chk
// Property checker for kmask_ortest. It is attached to the top module
// through bind and observes only the ports.
module kmask_ortest_chk (
    input logic clk,
    input logic rst_n,
    input logic issue,
    input logic flags_vld,
    input logic flag_zf,
    input logic flag_cf,
    input logic flag_of,
    input logic flag_sf,
    input logic flag_af,
    input logic flag_pf
);

    // R1: the first edge after reset release still shows the cleared outputs.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!flags_vld && !flag_zf && !flag_cf));

    // R4: zero and all-ones cannot both hold on a width of one bit or more.
    p_zf_cf_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_zf && flag_cf));

    // R7: the side flags stay zero.
    p_side_flags_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_of || flag_sf || flag_af || flag_pf));

    // R8: valid is raised exactly one cycle after issue.
    p_vld_after_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> flags_vld);

    // R8: valid stays low when there was no issue.
    p_no_vld_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> !flags_vld);

    // R9: the flags hold through a cycle with no issue.
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !issue |=> ($stable(flag_zf) && $stable(flag_cf)));

endmodule

bind kmask_ortest kmask_ortest_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (issue),
    .flags_vld (flags_vld),
    .flag_zf   (flag_zf),
    .flag_cf   (flag_cf),
    .flag_of   (flag_of),
    .flag_sf   (flag_sf),
    .flag_af   (flag_af),
    .flag_pf   (flag_pf)
);

// File: tb/test_kmask_ortest.sv
`timescale 1ns/1ps
// Bench for kmask_ortest. It sweeps every width and every register pair
// over two register images, and computes the expected flags
// arithmetically from a bench-side model of the register contents.
module test_kmask_ortest;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_data = '0;
    logic        issue = 1'b0;
    logic [2:0]  src_a_idx = '0;
    logic [2:0]  src_b_idx = '0;
    logic        pfx66 = 1'b0;
    logic        wbit = 1'b0;
    logic        flags_vld, flag_zf, flag_cf, flag_of, flag_sf, flag_af, flag_pf;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          finished = 1'b0;
    logic [63:0] mdl [8];

    always #2 clk = ~clk;

    kmask_ortest i_kmask_ortest (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .issue     (issue),
        .src_a_idx (src_a_idx),
        .src_b_idx (src_b_idx),
        .pfx66     (pfx66),
        .wbit      (wbit),
        .flags_vld (flags_vld),
        .flag_zf   (flag_zf),
        .flag_cf   (flag_cf),
        .flag_of   (flag_of),
        .flag_sf   (flag_sf),
        .flag_af   (flag_af),
        .flag_pf   (flag_pf)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Width in bits from the decode table of R5.
    function automatic int exp_width(input bit p, input bit w);
        case ({p, w})
            2'b00:   return 16;
            2'b10:   return 8;
            2'b01:   return 64;
            default: return 32;
        endcase
    endfunction

    function automatic logic [63:0] width_mask(input int n);
        return (n >= 64) ? {64{1'b1}} : ((64'd1 << n) - 64'd1);
    endfunction

    task automatic write_reg(input int idx, input logic [63:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[idx] = v;
    endtask

    task automatic check_flags(input logic [63:0] a, input logic [63:0] b,
                               input bit p, input bit w, input string req);
        logic [63:0] m;
        logic [63:0] t;
        m = width_mask(exp_width(p, w));
        t = (a | b) & m;
        check(flags_vld == 1'b1, "R8", "valid", 64'(flags_vld), 64'd1);
        check(flag_zf == (t == 64'd0), req, "zero flag", 64'(flag_zf), 64'(t == 64'd0));
        check(flag_cf == (t == m), req, "carry flag", 64'(flag_cf), 64'(t == m));
        check({flag_of, flag_sf, flag_af, flag_pf} == 4'b0, "R7", "side flags",
              64'({flag_of, flag_sf, flag_af, flag_pf}), 64'd0);
    endtask

    // Issue one test, check it, then check that an idle cycle with scrambled inputs holds the flags.
    task automatic run_test(input int a, input int b, input bit p, input bit w, input string req);
        logic zf_s;
        logic cf_s;
        @(negedge clk);
        issue = 1'b1; src_a_idx = 3'(a); src_b_idx = 3'(b); pfx66 = p; wbit = w;
        @(negedge clk);
        issue = 1'b0;
        check_flags(mdl[a], mdl[b], p, w, req);
        zf_s = flag_zf; cf_s = flag_cf;
        src_a_idx = ~src_a_idx; pfx66 = ~pfx66; wbit = ~wbit;
        @(negedge clk);
        check(flags_vld == 1'b0, "R8", "valid idle", 64'(flags_vld), 64'd0);
        check(flag_zf == zf_s && flag_cf == cf_s, "R9", "hold",
              64'({flag_zf, flag_cf}), 64'({zf_s, cf_s}));
    endtask

    task automatic sweep(input string req);
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++)
                    run_test(a, b, m[1], m[0], req);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(!flags_vld && !flag_zf && !flag_cf, "R1", "reset outputs",
              64'({flags_vld, flag_zf, flag_cf}), 64'd0);
        run_test(3, 6, 1'b0, 1'b1, "R1");
        check(flag_zf == 1'b1, "R1", "cleared regs give zero", 64'(flag_zf), 64'd1);

        // First image: targeted patterns for each width.
        write_reg(0, 64'h0);
        write_reg(1, 64'hFFFF_FFFF_FFFF_FFFF);
        write_reg(2, 64'h0000_0000_0000_00FF);
        write_reg(3, 64'h0000_0000_0000_FF00);
        write_reg(4, 64'hFFFF_FFFF_0000_0000);
        write_reg(5, 64'h0000_0000_FFFF_0000);
        write_reg(6, 64'hA5A5_A5A5_A5A5_A5FF);
        write_reg(7, 64'h5555_5555_5555_5555);
        sweep("R3 R4 R5");

        // R4: 16-bit width, k2|k3 = 0xFFFF sets carry.
        run_test(2, 3, 1'b0, 1'b0, "R4");
        check(flag_cf == 1'b1, "R4", "16-bit all ones", 64'(flag_cf), 64'd1);
        // R6: upper-only bits ignored at 32 bits; low byte all ones carries at 8 bits.
        run_test(4, 0, 1'b1, 1'b1, "R6");
        check(flag_zf == 1'b1, "R6", "upper bits ignored", 64'(flag_zf), 64'd1);
        run_test(6, 6, 1'b1, 1'b0, "R6");
        check(flag_cf == 1'b1, "R6", "8-bit carry despite upper", 64'(flag_cf), 64'd1);
        // R5: same sources (k2|k5 = 0xFFFF00FF) give different flags per width.
        run_test(2, 5, 1'b1, 1'b0, "R5");
        check(flag_cf == 1'b1, "R5", "8-bit carry", 64'(flag_cf), 64'd1);
        run_test(2, 5, 1'b0, 1'b0, "R5");
        check(flag_cf == 1'b0 && flag_zf == 1'b0, "R5", "16-bit mixed",
              64'({flag_zf, flag_cf}), 64'd0);

        // Second image: values from an arithmetic generator, with some forced extremes.
        for (int i = 0; i < 8; i++) begin
            logic [63:0] v;
            v = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 3);
            if (i == 1) v = v | 64'h0000_0000_FFFF_FFFF;
            if (i == 5) v = v & 64'hFFFF_FFFF_FFFF_0000;
            write_reg(i, v);
        end
        sweep("R3 R4 R5 R6");

        // R10: sources unchanged after many tests.
        for (int i = 0; i < 8; i++) run_test(i, i, 1'b0, 1'b1, "R10");

        // R2: a same-cycle write and test see the old value.
        write_reg(2, 64'h0);
        write_reg(0, 64'h0);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd2; wr_data = {64{1'b1}};
        issue = 1'b1; src_a_idx = 3'd2; src_b_idx = 3'd0; pfx66 = 1'b0; wbit = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; issue = 1'b0;
        check(flag_zf == 1'b1 && flag_cf == 1'b0, "R2", "old value seen",
              64'({flag_zf, flag_cf}), 64'b10);
        mdl[2] = {64{1'b1}};
        run_test(2, 0, 1'b0, 1'b1, "R2");
        check(flag_cf == 1'b1, "R2", "new value seen", 64'(flag_cf), 64'd1);

        // R1: a reset in mid-run clears registers and flags.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!flags_vld && !flag_zf && !flag_cf, "R1", "mid-run reset",
              64'({flags_vld, flag_zf, flag_cf}), 64'd0);
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        run_test(1, 2, 1'b0, 1'b1, "R1");
        check(flag_zf == 1'b1, "R1", "regs cleared", 64'(flag_zf), 64'd1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule